// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the small set of privileged machine-control registers that a processor core reaches through its move-to and move-from privileged-register commands. Each command carries a register index, a direction bit and, for writes, a 64-bit data word. One cycle later the block answers with read data, the value the register held before the write (for the registers that define one) and an error flag. Reads come back sign-extended from each register's natural width.

Several registers do not simply store what they are given. The asynchronous-trap enable and summary registers merge new bits with the old ones by AND and OR. The machine-check status register clears some bits when a one is written and loads others directly. A software interrupt request write sets one bit of the interrupt summary, chosen by its index. Translation-buffer invalidate writes leave a one-cycle pulse, together with the written address where there is one. Feature-enable inputs hide the address-space number and the virtual-bound pair of registers, and a privilege input guards the kernel stack pointer.

The block takes one command per cycle and is always ready, so there is no back-pressure on the command side. The response side also has no back-pressure: the receiver takes each response in the cycle that `rsp_valid` is high.

Top module: `prf_top`

## Requirements
- R1: When `cmd_valid` is high at a clock edge, `rsp_valid` is high for the following cycle, together with that command's `rsp_rdata`, `rsp_old`, `rsp_old_valid` and `rsp_err`. Read data reflects state before the command. A command issued in the next cycle already sees the state that this command wrote. Write responses return `rsp_rdata` = 0.
- R2: The trap-enable register (index 1) and the trap-summary register (index 2) are 4 bits wide. A write stores (old AND data[3:0]) OR data[7:4], raises `rsp_old_valid` and returns the previous value, sign-extended from 4 bits, on `rsp_old`.
- R3: The interrupt priority level (index 4) is 5 bits wide. A write stores data[4:0] and returns the previous level, sign-extended from 5 bits, on `rsp_old` with `rsp_old_valid` high.
- R4: The machine-check status register (index 5) is 5 bits wide. A write clears each of bits 0 to 2 whose data bit is 1 and loads bits 3 and 4 from data[4:3]. A pulse on `mcheck_set[i]` sets bit i. A write returns no old value.
- R5: A write to the software request register (index 10) with a nonzero data[3:0] sets that bit number in the 16-bit software interrupt summary (index 11). A write with data[3:0] = 0 leaves the summary unchanged.
- R6: Reads are sign-extended from the register's width: 4 bits for indices 1 and 2, 5 bits for indices 4 and 5, 1 bit for the FP-enable register (index 3, a write stores data[0]), 16 bits for index 11, 32 bits for the trap-table base (index 9) and 48 bits for the process-context base (index 12, constant `PCB_INIT`).
- R7: An access is refused with `rsp_err` = 1, `rsp_rdata` = 0 and no state change in these cases: a read of a write-only index (10, 16 or 17); a write to a read-only index (0 address-space number, 8 page-table base, 11, 12, or 18 processor id); or any index above 18.
- R8: The kernel stack pointer (index 6, 64 bits) can be read or written only while `priv_mode` is 1. Otherwise the access is refused as in R7.
- R9: A write to index 16 gives a one-cycle `tlb_flush_all` pulse. A write to index 17 gives a one-cycle `tlb_flush_one` pulse with `tlb_flush_addr` equal to the written data. Both pulses come in the response cycle, and at most one of them is high at a time.
- R10: With `feat_asn` = 0 a read of index 0 returns zero; with `feat_asn` = 1 it returns `ASN_VAL`, zero-extended. With `feat_vbound` = 0 any access to the virtual-bound register (index 13) or the system page-table base (index 14) is refused. With `feat_vbound` = 1 both are plain 64-bit registers.
- R11: The trap-table base (index 9) stores only data[31:0]. The processor-bound register (index 7) and the virtual page-table base (index 15) store all 64 bits.
- R12: After reset every writable register reads zero and no response or pulse is active. Index 18 reads `CPU_ID` and index 8 reads `PTB_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| cmd_idx | input | 6 | Register index |
| cmd_wdata | input | 64 | Write data |
| priv_mode | input | 1 | Privileged mode, gates the kernel stack pointer |
| feat_asn | input | 1 | Address-space-number feature present |
| feat_vbound | input | 1 | Virtual-bound feature present |
| mcheck_set | input | 3 | Hardware set of machine-check status bits 0..2 |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Sign-extended read data |
| rsp_old | output | 64 | Previous value for writes that return one |
| rsp_old_valid | output | 1 | rsp_old carries a value |
| rsp_err | output | 1 | Access refused |
| tlb_flush_all | output | 1 | Invalidate-all pulse |
| tlb_flush_one | output | 1 | Invalidate-single pulse |
| tlb_flush_addr | output | 64 | Address for the invalidate-single pulse |

## Verification
The bench builds the block with `PCB_INIT` = 64'h0000_9234_5678_9ABC. Bit 47 of that value is set, so the 48-bit sign extension of the process-context base shows up as ones in the upper bits. `CPU_ID` = 3, `PTB_INIT` = 64'h0000_0000_0042_0000 and `ASN_VAL` = 8'h5A give the read-only registers values that differ from zero and from one another, so a swapped read path is caught. The width parameters keep their defaults: 16 summary bits (the largest request index, 15, is reachable), 32 trap-table bits and 48 context-base bits.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int XLEN  = 64;
  localparam int IDX_W = 6;

  localparam logic [IDX_W-1:0] IX_ASN    = 6'd0;
  localparam logic [IDX_W-1:0] IX_TRPEN  = 6'd1;
  localparam logic [IDX_W-1:0] IX_TRPSUM = 6'd2;
  localparam logic [IDX_W-1:0] IX_FPEN   = 6'd3;
  localparam logic [IDX_W-1:0] IX_IPL    = 6'd4;
  localparam logic [IDX_W-1:0] IX_MCHK   = 6'd5;
  localparam logic [IDX_W-1:0] IX_KSP    = 6'd6;
  localparam logic [IDX_W-1:0] IX_PRBND  = 6'd7;
  localparam logic [IDX_W-1:0] IX_PTB    = 6'd8;
  localparam logic [IDX_W-1:0] IX_TRPTAB = 6'd9;
  localparam logic [IDX_W-1:0] IX_SWREQ  = 6'd10;
  localparam logic [IDX_W-1:0] IX_SWSUM  = 6'd11;
  localparam logic [IDX_W-1:0] IX_PCB    = 6'd12;
  localparam logic [IDX_W-1:0] IX_VBND   = 6'd13;
  localparam logic [IDX_W-1:0] IX_SYSPTB = 6'd14;
  localparam logic [IDX_W-1:0] IX_VPTB   = 6'd15;
  localparam logic [IDX_W-1:0] IX_INVALL = 6'd16;
  localparam logic [IDX_W-1:0] IX_INVONE = 6'd17;
  localparam logic [IDX_W-1:0] IX_CPUID  = 6'd18;

  // slots of the plain full-width register array
  localparam int WIDE_N    = 5;
  localparam int WS_KSP    = 0;
  localparam int WS_PRBND  = 1;
  localparam int WS_VBND   = 2;
  localparam int WS_SYSPTB = 3;
  localparam int WS_VPTB   = 4;

  localparam int TRP_W  = 4;
  localparam int IPL_W  = 5;
  localparam int MCHK_W = 5;

  typedef struct packed {
    logic              err;
    logic              we_trpen;
    logic              we_trpsum;
    logic              we_fpen;
    logic              we_ipl;
    logic              we_mchk;
    logic              we_trptab;
    logic              we_swreq;
    logic              flush_all;
    logic              flush_one;
    logic              ret_old;
    logic [WIDE_N-1:0] we_wide;
  } prf_ctl_t;

  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] v, input int w);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction
endpackage

// File: rtl/prf_decode.sv
module prf_decode
  import prf_pkg::*;
(
  input  logic             valid,
  input  logic             write,
  input  logic [IDX_W-1:0] idx,
  input  logic             priv_mode,
  input  logic             feat_vbound,
  output prf_ctl_t         ctl
);
  prf_ctl_t c;
  logic     refuse;

  always_comb begin
    c      = '0;
    refuse = 1'b0;
    unique case (idx)
      IX_ASN, IX_PTB, IX_SWSUM, IX_PCB, IX_CPUID: refuse = write;
      IX_TRPEN:  begin c.we_trpen  = write; c.ret_old = write; end
      IX_TRPSUM: begin c.we_trpsum = write; c.ret_old = write; end
      IX_FPEN:   c.we_fpen = write;
      IX_IPL:    begin c.we_ipl = write; c.ret_old = write; end
      IX_MCHK:   c.we_mchk = write;
      IX_KSP: begin
        refuse = !priv_mode;
        c.we_wide[WS_KSP] = write;
      end
      IX_PRBND:  c.we_wide[WS_PRBND] = write;
      IX_TRPTAB: c.we_trptab = write;
      IX_SWREQ:  begin refuse = !write; c.we_swreq = write; end
      IX_VBND: begin
        refuse = !feat_vbound;
        c.we_wide[WS_VBND] = write;
      end
      IX_SYSPTB: begin
        refuse = !feat_vbound;
        c.we_wide[WS_SYSPTB] = write;
      end
      IX_VPTB:   c.we_wide[WS_VPTB] = write;
      IX_INVALL: begin refuse = !write; c.flush_all = write; end
      IX_INVONE: begin refuse = !write; c.flush_one = write; end
      default:   refuse = 1'b1;
    endcase
  end

  // a refused or absent command enables nothing
  always_comb begin
    if (!valid || refuse) begin
      ctl     = '0;
      ctl.err = valid;
    end else begin
      ctl     = c;
      ctl.err = 1'b0;
    end
  end
endmodule

// File: rtl/prf_state.sv
module prf_state
  import prf_pkg::*;
#(
  parameter int SUM_W = 16,
  parameter int TAB_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  prf_ctl_t                    ctl,
  input  logic [XLEN-1:0]             wdata,
  input  logic [2:0]                  mcheck_set,
  output logic [TRP_W-1:0]            trpen_q,
  output logic [TRP_W-1:0]            trpsum_q,
  output logic                        fpen_q,
  output logic [IPL_W-1:0]            ipl_q,
  output logic [MCHK_W-1:0]           mchk_q,
  output logic [TAB_W-1:0]            trptab_q,
  output logic [SUM_W-1:0]            swsum_q,
  output logic [WIDE_N-1:0][XLEN-1:0] wide_q
);
  localparam int SUM_IW = $clog2(SUM_W);

  logic [SUM_IW-1:0] req_bit;
  logic [2:0]        mc_clr;
  logic [2:0]        mc_low_nx;
  logic [1:0]        mc_high_nx;

  assign req_bit    = wdata[SUM_IW-1:0];
  assign mc_clr     = ctl.we_mchk ? wdata[2:0] : 3'b000;
  // a hardware report in the same cycle as a clear is kept
  assign mc_low_nx  = (mchk_q[2:0] & ~mc_clr) | mcheck_set;
  assign mc_high_nx = ctl.we_mchk ? wdata[4:3] : mchk_q[4:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trpen_q  <= '0;
      trpsum_q <= '0;
      fpen_q   <= 1'b0;
      ipl_q    <= '0;
      mchk_q   <= '0;
      trptab_q <= '0;
      swsum_q  <= '0;
    end else begin
      if (ctl.we_trpen)  trpen_q  <= (trpen_q  & wdata[TRP_W-1:0]) | wdata[2*TRP_W-1:TRP_W];
      if (ctl.we_trpsum) trpsum_q <= (trpsum_q & wdata[TRP_W-1:0]) | wdata[2*TRP_W-1:TRP_W];
      if (ctl.we_fpen)   fpen_q   <= wdata[0];
      if (ctl.we_ipl)    ipl_q    <= wdata[IPL_W-1:0];
      if (ctl.we_trptab) trptab_q <= wdata[TAB_W-1:0];
      mchk_q <= {mc_high_nx, mc_low_nx};
      if (ctl.we_swreq && (req_bit != '0)) swsum_q[req_bit] <= 1'b1;
    end
  end

  for (genvar g = 0; g < WIDE_N; g++) begin : g_wide
    always_ff @(posedge clk) begin
      if (!rst_n)              wide_q[g] <= '0;
      else if (ctl.we_wide[g]) wide_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/prf_rdmux.sv
module prf_rdmux
  import prf_pkg::*;
#(
  parameter int              SUM_W    = 16,
  parameter int              TAB_W    = 32,
  parameter int              PCB_W    = 48,
  parameter int              ASN_W    = 8,
  parameter logic [XLEN-1:0] CPU_ID   = 64'd0,
  parameter logic [XLEN-1:0] PTB_INIT = 64'd0,
  parameter logic [XLEN-1:0] PCB_INIT = 64'd0,
  parameter logic [ASN_W-1:0] ASN_VAL = '0
) (
  input  logic [IDX_W-1:0]            idx,
  input  logic                        feat_asn,
  input  logic [TRP_W-1:0]            trpen_q,
  input  logic [TRP_W-1:0]            trpsum_q,
  input  logic                        fpen_q,
  input  logic [IPL_W-1:0]            ipl_q,
  input  logic [MCHK_W-1:0]           mchk_q,
  input  logic [TAB_W-1:0]            trptab_q,
  input  logic [SUM_W-1:0]            swsum_q,
  input  logic [WIDE_N-1:0][XLEN-1:0] wide_q,
  output logic [XLEN-1:0]             rd
);
  localparam logic [XLEN-1:0] PCB_EXT = sext(PCB_INIT, PCB_W);

  always_comb begin
    rd = '0;
    unique case (idx)
      IX_ASN:    rd = feat_asn ? XLEN'(ASN_VAL) : '0;
      IX_TRPEN:  rd = sext(XLEN'(trpen_q), TRP_W);
      IX_TRPSUM: rd = sext(XLEN'(trpsum_q), TRP_W);
      IX_FPEN:   rd = {XLEN{fpen_q}};
      IX_IPL:    rd = sext(XLEN'(ipl_q), IPL_W);
      IX_MCHK:   rd = sext(XLEN'(mchk_q), MCHK_W);
      IX_KSP:    rd = wide_q[WS_KSP];
      IX_PRBND:  rd = wide_q[WS_PRBND];
      IX_PTB:    rd = PTB_INIT;
      IX_TRPTAB: rd = sext(XLEN'(trptab_q), TAB_W);
      IX_SWSUM:  rd = sext(XLEN'(swsum_q), SUM_W);
      IX_PCB:    rd = PCB_EXT;
      IX_VBND:   rd = wide_q[WS_VBND];
      IX_SYSPTB: rd = wide_q[WS_SYSPTB];
      IX_VPTB:   rd = wide_q[WS_VPTB];
      IX_CPUID:  rd = CPU_ID;
      default:   rd = '0;
    endcase
  end
endmodule

// File: rtl/prf_top.sv
module prf_top
  import prf_pkg::*;
#(
  parameter int              SUM_W    = 16,
  parameter int              TAB_W    = 32,
  parameter int              PCB_W    = 48,
  parameter int              ASN_W    = 8,
  parameter logic [63:0]     CPU_ID   = 64'd0,
  parameter logic [63:0]     PTB_INIT = 64'd0,
  parameter logic [63:0]     PCB_INIT = 64'd0,
  parameter logic [ASN_W-1:0] ASN_VAL = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [5:0]  cmd_idx,
  input  logic [63:0] cmd_wdata,
  input  logic        priv_mode,
  input  logic        feat_asn,
  input  logic        feat_vbound,
  input  logic [2:0]  mcheck_set,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic [63:0] rsp_old,
  output logic        rsp_old_valid,
  output logic        rsp_err,
  output logic        tlb_flush_all,
  output logic        tlb_flush_one,
  output logic [63:0] tlb_flush_addr
);
  prf_ctl_t                    ctl;
  logic [TRP_W-1:0]            trpen_q, trpsum_q;
  logic                        fpen_q;
  logic [IPL_W-1:0]            ipl_q;
  logic [MCHK_W-1:0]           mchk_q;
  logic [TAB_W-1:0]            trptab_q;
  logic [SUM_W-1:0]            swsum_q;
  logic [WIDE_N-1:0][XLEN-1:0] wide_q;
  logic [XLEN-1:0]             rd;
  logic                        rd_ok;

  prf_decode u_dec (
    .valid(cmd_valid), .write(cmd_write), .idx(cmd_idx),
    .priv_mode(priv_mode), .feat_vbound(feat_vbound), .ctl(ctl)
  );

  prf_state #(.SUM_W(SUM_W), .TAB_W(TAB_W)) u_st (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wdata(cmd_wdata),
    .mcheck_set(mcheck_set), .trpen_q(trpen_q), .trpsum_q(trpsum_q),
    .fpen_q(fpen_q), .ipl_q(ipl_q), .mchk_q(mchk_q), .trptab_q(trptab_q),
    .swsum_q(swsum_q), .wide_q(wide_q)
  );

  prf_rdmux #(
    .SUM_W(SUM_W), .TAB_W(TAB_W), .PCB_W(PCB_W), .ASN_W(ASN_W),
    .CPU_ID(CPU_ID), .PTB_INIT(PTB_INIT), .PCB_INIT(PCB_INIT), .ASN_VAL(ASN_VAL)
  ) u_rd (
    .idx(cmd_idx), .feat_asn(feat_asn), .trpen_q(trpen_q), .trpsum_q(trpsum_q),
    .fpen_q(fpen_q), .ipl_q(ipl_q), .mchk_q(mchk_q), .trptab_q(trptab_q),
    .swsum_q(swsum_q), .wide_q(wide_q), .rd(rd)
  );

  assign rd_ok = cmd_valid && !cmd_write && !ctl.err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_old        <= '0;
      rsp_old_valid  <= 1'b0;
      rsp_err        <= 1'b0;
      tlb_flush_all  <= 1'b0;
      tlb_flush_one  <= 1'b0;
      tlb_flush_addr <= '0;
    end else begin
      rsp_valid     <= cmd_valid;
      rsp_err       <= ctl.err;
      rsp_rdata     <= rd_ok ? rd : '0;
      rsp_old_valid <= ctl.ret_old;
      rsp_old       <= ctl.ret_old ? rd : '0;
      tlb_flush_all <= ctl.flush_all;
      tlb_flush_one <= ctl.flush_one;
      if (ctl.flush_one) tlb_flush_addr <= cmd_wdata;
    end
  end
endmodule

// File: rtl/prf_chk.sv
module prf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_write,
  input logic [5:0]  cmd_idx,
  input logic [63:0] cmd_wdata,
  input logic        priv_mode,
  input logic        feat_vbound,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        rsp_old_valid,
  input logic        rsp_err,
  input logic        tlb_flush_all,
  input logic        tlb_flush_one,
  input logic [63:0] tlb_flush_addr
);
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R1
  AST_RSP_ONLY_FOR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid && !rsp_err); // R1
  AST_IPL_OLD_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && cmd_idx == 6'd4 |=> rsp_old_valid && !rsp_err); // R3
  AST_IPL_READ_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && cmd_idx == 6'd4 |=> rsp_rdata[63:5] == {59{rsp_rdata[4]}}); // R6
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 64'd0 && !rsp_old_valid && !tlb_flush_all && !tlb_flush_one); // R7
  AST_WO_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write && cmd_idx == 6'd10 |=> rsp_err); // R7
  AST_KSP_NEEDS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_idx == 6'd6 && !priv_mode |=> rsp_err); // R8
  AST_FLUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_flush_all, tlb_flush_one})); // R9
  AST_FLUSH_ONE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && cmd_idx == 6'd17 |=> tlb_flush_one && tlb_flush_addr == $past(cmd_wdata)); // R9
  AST_VBOUND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_idx == 6'd13 && !feat_vbound |=> rsp_err); // R10
endmodule

bind prf_top prf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .priv_mode(priv_mode),
  .feat_vbound(feat_vbound), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_old_valid(rsp_old_valid), .rsp_err(rsp_err), .tlb_flush_all(tlb_flush_all),
  .tlb_flush_one(tlb_flush_one), .tlb_flush_addr(tlb_flush_addr)
);

// File: tb/test_prf_top.sv
`timescale 1ns/1ps
module test_prf_top;
  localparam logic [63:0] P_CPU = 64'd3;
  localparam logic [63:0] P_PTB = 64'h0000_0000_0042_0000;
  localparam logic [63:0] P_PCB = 64'h0000_9234_5678_9ABC;
  localparam logic [7:0]  P_ASN = 8'h5A;
  localparam logic [63:0] ONES  = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [5:0] cmd_idx = '0;
  logic [63:0] cmd_wdata = '0;
  logic priv_mode = 1'b0, feat_asn = 1'b0, feat_vbound = 1'b0;
  logic [2:0] mcheck_set = '0;
  logic rsp_valid, rsp_old_valid, rsp_err, tlb_flush_all, tlb_flush_one;
  logic [63:0] rsp_rdata, rsp_old, tlb_flush_addr;

  int n_chk = 0, n_bad = 0;
  logic [63:0] r_data, r_old;
  logic r_err, r_oldv, r_valid, r_fa, r_fo;
  logic [63:0] r_fadr;

  always #2 clk = ~clk;

  prf_top #(.CPU_ID(P_CPU), .PTB_INIT(P_PTB), .PCB_INIT(P_PCB), .ASN_VAL(P_ASN)) i_prf_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .priv_mode(priv_mode),
    .feat_asn(feat_asn), .feat_vbound(feat_vbound), .mcheck_set(mcheck_set),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_old(rsp_old),
    .rsp_old_valid(rsp_old_valid), .rsp_err(rsp_err), .tlb_flush_all(tlb_flush_all),
    .tlb_flush_one(tlb_flush_one), .tlb_flush_addr(tlb_flush_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic grab();
    r_valid = rsp_valid; r_data = rsp_rdata; r_old = rsp_old; r_err = rsp_err;
    r_oldv = rsp_old_valid; r_fa = tlb_flush_all; r_fo = tlb_flush_one; r_fadr = tlb_flush_addr;
  endtask

  // one command; the response is sampled 1 ns after the edge that registers it
  task automatic op(input logic w, input logic [5:0] idx, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_idx = idx; cmd_wdata = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    grab();
  endtask

  task automatic rd_chk(input string req, input logic [5:0] idx, input logic [63:0] exp);
    op(1'b0, idx, 64'd0);
    chk(req, {63'd0, r_err}, 64'd0);
    chk(req, r_data, exp);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk("R12 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    chk("R12 no flush", {62'd0, tlb_flush_all, tlb_flush_one}, 64'd0);
    rd_chk("R12 cpu id", 6'd18, P_CPU);
    rd_chk("R12 ptb", 6'd8, P_PTB);
    rd_chk("R12 ipl zero", 6'd4, 64'd0);
    rd_chk("R12 vptb zero", 6'd15, 64'd0);
  endtask

  task automatic t_trap();
    op(1'b1, 6'd1, 64'hF0);
    chk("R2 old valid", {63'd0, r_oldv}, 64'd1);
    chk("R2 old zero", r_old, 64'd0);
    chk("R1 write rdata zero", r_data, 64'd0);
    rd_chk("R2 r6_ trap enable sext", 6'd1, ONES);
    op(1'b1, 6'd1, 64'h13);
    chk("R2 old sext", r_old, ONES);
    rd_chk("R2 merge", 6'd1, 64'd3);
    op(1'b1, 6'd2, 64'h50);
    rd_chk("R2 trap summary", 6'd2, 64'd5);
  endtask

  task automatic t_ipl();
    op(1'b1, 6'd4, 64'h1F);
    chk("R3 old", r_old, 64'd0);
    rd_chk("R3 r6_ ipl sext", 6'd4, ONES);
    op(1'b1, 6'd4, 64'h25);
    chk("R3 old level", r_old, ONES);
    chk("R3 old valid", {63'd0, r_oldv}, 64'd1);
    rd_chk("R3 low bits", 6'd4, 64'd5);
  endtask

  task automatic t_mchk();
    @(negedge clk); mcheck_set = 3'b101;
    @(negedge clk); mcheck_set = 3'b000;
    rd_chk("R4 hw set", 6'd5, 64'd5);
    op(1'b1, 6'd5, 64'h04);
    chk("R4 no old", {63'd0, r_oldv}, 64'd0);
    rd_chk("R4 w1c", 6'd5, 64'd1);
    op(1'b1, 6'd5, 64'h18);
    rd_chk("R4 r6_ load high", 6'd5, 64'hFFFF_FFFF_FFFF_FFF9);
  endtask

  task automatic t_swint();
    op(1'b1, 6'd10, 64'h0);
    rd_chk("R5 zero index", 6'd11, 64'd0);
    op(1'b1, 6'd10, 64'h5);
    rd_chk("R5 bit5", 6'd11, 64'h20);
    op(1'b1, 6'd10, 64'hF);
    rd_chk("R5 r6_ bit15 sext", 6'd11, 64'hFFFF_FFFF_FFFF_8020);
    op(1'b1, 6'd10, 64'h13);
    rd_chk("R5 low nibble only", 6'd11, 64'hFFFF_FFFF_FFFF_8028);
  endtask

  task automatic t_widths();
    op(1'b1, 6'd3, 64'h3);
    rd_chk("R6 fpen set", 6'd3, ONES);
    op(1'b1, 6'd3, 64'h2);
    rd_chk("R6 fpen clear", 6'd3, 64'd0);
    rd_chk("R6 pcb 48-bit sext", 6'd12, 64'hFFFF_9234_5678_9ABC);
    op(1'b1, 6'd9, 64'h1234_5678_8000_0001);
    rd_chk("R11 r6_ trap table sext", 6'd9, 64'hFFFF_FFFF_8000_0001);
    op(1'b1, 6'd9, 64'hFFFF_0000_1234_5678);
    rd_chk("R11 low 32 only", 6'd9, 64'h0000_0000_1234_5678);
    op(1'b1, 6'd7, 64'hA5A5_0000_1111_2222);
    rd_chk("R11 prbnd full", 6'd7, 64'hA5A5_0000_1111_2222);
  endtask

  task automatic t_errors();
    op(1'b0, 6'd10, 64'd0);
    chk("R7 read write-only", {63'd0, r_err}, 64'd1);
    chk("R7 err rdata", r_data, 64'd0);
    op(1'b1, 6'd0, 64'h77);
    chk("R7 write asn", {63'd0, r_err}, 64'd1);
    op(1'b1, 6'd18, 64'h9);
    chk("R7 write cpu id", {63'd0, r_err}, 64'd1);
    rd_chk("R7 cpu id unchanged", 6'd18, P_CPU);
    op(1'b1, 6'd11, 64'h0);
    chk("R7 write summary", {63'd0, r_err}, 64'd1);
    rd_chk("R7 summary unchanged", 6'd11, 64'hFFFF_FFFF_FFFF_8028);
    op(1'b1, 6'd12, 64'h0);
    chk("R7 write pcb", {63'd0, r_err}, 64'd1);
    op(1'b0, 6'd19, 64'd0);
    chk("R7 unknown 19", {63'd0, r_err}, 64'd1);
    op(1'b1, 6'd63, 64'h1F);
    chk("R7 unknown 63", {63'd0, r_err}, 64'd1);
    rd_chk("R7 ipl untouched", 6'd4, 64'd5);
  endtask

  task automatic t_ksp();
    priv_mode = 1'b0;
    op(1'b1, 6'd6, 64'hAA);
    chk("R8 write unpriv", {63'd0, r_err}, 64'd1);
    op(1'b0, 6'd6, 64'd0);
    chk("R8 read unpriv", {63'd0, r_err}, 64'd1);
    priv_mode = 1'b1;
    rd_chk("R8 unchanged", 6'd6, 64'd0);
    op(1'b1, 6'd6, 64'h0000_DEAD_0000_BEEF);
    chk("R8 write priv", {63'd0, r_err}, 64'd0);
    rd_chk("R8 readback", 6'd6, 64'h0000_DEAD_0000_BEEF);
    priv_mode = 1'b0;
  endtask

  task automatic t_flush();
    op(1'b1, 6'd16, 64'h0);
    chk("R9 flush all", {62'd0, r_fa, r_fo}, 64'd2);
    @(posedge clk); #1; grab();
    chk("R9 one cycle", {62'd0, r_fa, r_fo}, 64'd0);
    op(1'b1, 6'd17, 64'h1234_5000);
    chk("R9 flush one", {62'd0, r_fa, r_fo}, 64'd1);
    chk("R9 flush addr", r_fadr, 64'h1234_5000);
    op(1'b0, 6'd17, 64'h0);
    chk("R9 read inv refused", {63'd0, r_err}, 64'd1);
    chk("R9 no pulse on refusal", {62'd0, r_fa, r_fo}, 64'd0);
  endtask

  task automatic t_feat();
    feat_asn = 1'b0;
    rd_chk("R10 asn hidden", 6'd0, 64'd0);
    feat_asn = 1'b1;
    rd_chk("R10 asn shown", 6'd0, 64'h5A);
    feat_vbound = 1'b0;
    op(1'b1, 6'd13, 64'h77);
    chk("R10 vbound gated", {63'd0, r_err}, 64'd1);
    op(1'b0, 6'd14, 64'h0);
    chk("R10 sysptb gated", {63'd0, r_err}, 64'd1);
    feat_vbound = 1'b1;
    rd_chk("R10 vbound unchanged", 6'd13, 64'd0);
    op(1'b1, 6'd13, 64'h77);
    rd_chk("R10 vbound", 6'd13, 64'h77);
    op(1'b1, 6'd14, 64'h88);
    rd_chk("R10 sysptb", 6'd14, 64'h88);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_idx = 6'd15; cmd_wdata = 64'h11;
    @(negedge clk);
    cmd_write = 1'b0; cmd_wdata = 64'h0;
    chk("R1 valid after write", {63'd0, rsp_valid}, 64'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk("R1 back-to-back read", rsp_rdata, 64'h11);
    chk("R1 valid", {63'd0, rsp_valid}, 64'd1);
    @(posedge clk); #1;
    chk("R1 idle no valid", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_trap();
    t_ipl();
    t_mchk();
    t_swint();
    t_widths();
    t_errors();
    t_ksp();
    t_flush();
    t_feat();
    t_b2b();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule